// File: doc/BRIEF.md
# Reservation Station Pool with Register Tag Renaming

This block sits between an in-order instruction stream and a set of functional units. It accepts one instruction per cycle and places it in a free reservation slot. Each source operand is either copied in as a value, when the architectural register holds one, or recorded as the tag of the slot that will produce it. The destination register is then marked as owned by the new slot. Slots and registers both watch a single result bus. A slot picks up a value when the tag on the bus matches the one it waits on. A register latches a result only if it still names that producer. Operands are read into private slot storage at issue, and registers drop results from stale producers, so the block removes write-after-read and write-after-write hazards without stalling.

Slots come in two groups. The add group serves add and subtract. The multiply group serves multiply and divide. Each group has its own dispatch port. A slot whose operands are both present is offered to the units, lowest index first. The slot stays occupied until its own result shows up on the bus. The functional units, their latencies and the producer of the result bus all live outside this block.

Top module: `rs_rename_core`

## Requirements
- R1: After reset every register holds value 0 with no pending producer, every slot is free, `iss_ready` is 1 and neither dispatch port is valid.
- R2: A source whose register has no pending producer is copied as a value at issue. An instruction issued with both operands present is offered on its dispatch port in the cycle after issue.
- R3: A source whose register has a pending producer is stored as that producer's tag. The slot is not dispatched while it waits. It captures the value in the cycle the matching tag is on the bus and is offered in the following cycle.
- R4: Issue sets the destination register's producer to the new slot, even when an older producer is still pending. A later reader of that register receives the newer producer's result.
- R5: A register latches a bus value and clears its pending state only when its recorded producer equals the bus tag. A result from a superseded producer leaves the register unchanged.
- R6: A value captured at issue is not affected by later results written to its source register.
- R7: When a source's producer broadcasts in the same cycle as the issue, the bus value is taken as the operand and the instruction is offered in the next cycle.
- R8: `iss_ready` is 0 when every slot of the group the opcode needs is occupied and none of them is freed by the bus in that cycle. A slot is freed in the cycle its own tag is on the bus, and an instruction may take it in that same cycle.
- R9: Tags are slot indices: the add group uses 0 to ADD_SLOTS-1 and the multiply group follows. Issue takes the lowest free slot of its group. Dispatch offers the lowest-index ready slot of the group, and each slot is offered once per occupancy.
- R10: A bus result whose tag matches no occupied slot and no pending register changes no register and no slot.
- R11: Opcodes are 2'b00 add and 2'b01 subtract, which go to the add group, and 2'b10 multiply and 2'b11 divide, which go to the multiply group. A dispatch port carries the opcode of the slot it offers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_valid | input | 1 | An instruction is presented |
| iss_ready | output | 1 | The target group has a slot for it |
| iss_op | input | 2 | Opcode |
| iss_dst | input | $clog2(NUM_REGS) | Destination register |
| iss_src1 | input | $clog2(NUM_REGS) | First source register |
| iss_src2 | input | $clog2(NUM_REGS) | Second source register |
| cdb_valid | input | 1 | A result is on the bus |
| cdb_tag | input | $clog2(ADD_SLOTS+MUL_SLOTS) | Slot that produced the result |
| cdb_value | input | DATA_W | Result value |
| add_go | output | 1 | Add group offers an operation |
| add_tag | output | $clog2(ADD_SLOTS+MUL_SLOTS) | Slot being offered |
| add_op | output | 2 | Opcode of that slot |
| add_opa | output | DATA_W | First operand |
| add_opb | output | DATA_W | Second operand |
| mul_go | output | 1 | Multiply group offers an operation |
| mul_tag | output | $clog2(ADD_SLOTS+MUL_SLOTS) | Slot being offered |
| mul_op | output | 2 | Opcode of that slot |
| mul_opa | output | DATA_W | First operand |
| mul_opb | output | DATA_W | Second operand |

## Verification
The hardest case to reach from the ports is a register whose producer has been superseded. An older multiply and a younger subtract must both target the same register, and their results must arrive newest first. Only then can the stale result try to overwrite the register. The bench acts as the functional units, so it picks the order of results on the bus itself. It sends the subtract result first and the multiply result after it, then issues a reader of that register and checks its dispatch operand. The same control over the bus lets the bench free a slot in the very cycle a full group is asked for. It also lets the bench send a result in the same cycle as the issue that needs it.

// File: rtl/rs_pkg.sv
// Shared opcode encoding for the reservation station pool.
// Assumes a 2-bit opcode whose upper bit selects the multiply group.
package rs_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MUL = 2'b10,
        OP_DIV = 2'b11
    } rs_op_e;

    // True when the opcode is served by the multiply/divide group.
    function automatic logic op_is_mul(input rs_op_e op);
        return op[1];
    endfunction

endpackage

// File: rtl/rs_pick.sv
// Lowest-index priority picker: one-hot grant, its index, and an any flag.
// Assumes N >= 1; IW is at least 1 bit wide.
module rs_pick #(
    parameter int N  = 2,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan from the top so the lowest requesting index is kept last.
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IW'(i);
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_regstat.sv
// Register status table: per register a value, a pending flag and a
// producer tag. Two read ports resolve a same-cycle bus result for the
// named producer. Rename of the destination wins over a bus latch.
// Assumes the caller only renames when an issue really fires.
module rs_regstat #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int TW       = 2,
    localparam int RW      = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_en,
    input  logic [RW-1:0]     ren_reg,
    input  logic [TW-1:0]     ren_tag,
    input  logic              cdb_valid,
    input  logic [TW-1:0]     cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    input  logic [RW-1:0]     rd_a_reg,
    input  logic [RW-1:0]     rd_b_reg,
    output logic              rd_a_pend,
    output logic [TW-1:0]     rd_a_tag,
    output logic [DATA_W-1:0] rd_a_val,
    output logic              rd_b_pend,
    output logic [TW-1:0]     rd_b_tag,
    output logic [DATA_W-1:0] rd_b_val
);
    logic [DATA_W-1:0] val_q  [NUM_REGS];
    logic [TW-1:0]     tag_q  [NUM_REGS];
    logic [NUM_REGS-1:0] pend_q;

    // Per-register update: rename first, else latch a matching result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            for (int i = 0; i < NUM_REGS; i++) begin
                val_q[i] <= '0;
                tag_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (ren_en && (ren_reg == RW'(i))) begin
                    pend_q[i] <= 1'b1;
                    tag_q[i]  <= ren_tag;
                end else if (pend_q[i] && cdb_valid && (cdb_tag == tag_q[i])) begin
                    val_q[i]  <= cdb_value;
                    pend_q[i] <= 1'b0;
                end
            end
        end
    end

    logic hit_a, hit_b;

    // Read port A with same-cycle bus forwarding.
    always_comb begin
        hit_a     = pend_q[rd_a_reg] && cdb_valid && (cdb_tag == tag_q[rd_a_reg]);
        rd_a_pend = pend_q[rd_a_reg] && !hit_a;
        rd_a_tag  = tag_q[rd_a_reg];
        rd_a_val  = hit_a ? cdb_value : val_q[rd_a_reg];
    end

    // Read port B with same-cycle bus forwarding.
    always_comb begin
        hit_b     = pend_q[rd_b_reg] && cdb_valid && (cdb_tag == tag_q[rd_b_reg]);
        rd_b_pend = pend_q[rd_b_reg] && !hit_b;
        rd_b_tag  = tag_q[rd_b_reg];
        rd_b_val  = hit_b ? cdb_value : val_q[rd_b_reg];
    end
endmodule

// File: rtl/rs_slot.sv
// One reservation slot. Holds an opcode and two operands, each either a
// value or a pending producer tag. Snoops the bus for operands and for its
// own result, which frees it. Assumes a granted slot is accepted at once
// and that its result arrives on the bus only after it was granted.
module rs_slot #(
    parameter int DATA_W = 32,
    parameter int TW     = 2,
    parameter int MY_TAG = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  rs_pkg::rs_op_e    alloc_op,
    input  logic              alloc_pj,
    input  logic [TW-1:0]     alloc_qj,
    input  logic [DATA_W-1:0] alloc_vj,
    input  logic              alloc_pk,
    input  logic [TW-1:0]     alloc_qk,
    input  logic [DATA_W-1:0] alloc_vk,
    input  logic              grant,
    input  logic              cdb_valid,
    input  logic [TW-1:0]     cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    output logic              busy_o,
    output logic              free_o,
    output logic              ready_o,
    output rs_pkg::rs_op_e    op_o,
    output logic [DATA_W-1:0] vj_o,
    output logic [DATA_W-1:0] vk_o
);
    logic              busy_q, sent_q, pj_q, pk_q;
    logic [TW-1:0]     qj_q, qk_q;
    logic [DATA_W-1:0] vj_q, vk_q;
    rs_pkg::rs_op_e    op_q;
    logic              done;

    // Own result on the bus releases the slot.
    assign done = busy_q && cdb_valid && (cdb_tag == TW'(MY_TAG));

    // Slot state: load on allocation, otherwise snoop, dispatch and free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sent_q <= 1'b0;
            pj_q   <= 1'b0;
            pk_q   <= 1'b0;
            qj_q   <= '0;
            qk_q   <= '0;
            vj_q   <= '0;
            vk_q   <= '0;
            op_q   <= rs_pkg::OP_ADD;
        end else if (alloc) begin
            busy_q <= 1'b1;
            sent_q <= 1'b0;
            op_q   <= alloc_op;
            pj_q   <= alloc_pj;
            qj_q   <= alloc_qj;
            vj_q   <= alloc_vj;
            pk_q   <= alloc_pk;
            qk_q   <= alloc_qk;
            vk_q   <= alloc_vk;
        end else begin
            if (done)
                busy_q <= 1'b0;
            if (grant)
                sent_q <= 1'b1;
            if (busy_q && pj_q && cdb_valid && (cdb_tag == qj_q)) begin
                vj_q <= cdb_value;
                pj_q <= 1'b0;
            end
            if (busy_q && pk_q && cdb_valid && (cdb_tag == qk_q)) begin
                vk_q <= cdb_value;
                pk_q <= 1'b0;
            end
        end
    end

    assign busy_o  = busy_q;
    assign free_o  = !busy_q || done;
    assign ready_o = busy_q && !sent_q && !pj_q && !pk_q;
    assign op_o    = op_q;
    assign vj_o    = vj_q;
    assign vk_o    = vk_q;
endmodule

// File: rtl/rs_rename_core.sv
// Dispatch core: register status table plus an add group and a multiply
// group of reservation slots sharing one result bus. Issues in order, one
// instruction per cycle, and offers ready slots to the units per group.
// Assumes the units accept every offer and return each result once.
module rs_rename_core #(
    parameter int NUM_REGS  = 8,
    parameter int DATA_W    = 32,
    parameter int ADD_SLOTS = 2,
    parameter int MUL_SLOTS = 2,
    localparam int RW       = $clog2(NUM_REGS),
    localparam int NS       = ADD_SLOTS + MUL_SLOTS,
    localparam int TW       = $clog2(NS),
    localparam int AIW      = (ADD_SLOTS > 1) ? $clog2(ADD_SLOTS) : 1,
    localparam int MIW      = (MUL_SLOTS > 1) ? $clog2(MUL_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    output logic              iss_ready,
    input  logic [1:0]        iss_op,
    input  logic [RW-1:0]     iss_dst,
    input  logic [RW-1:0]     iss_src1,
    input  logic [RW-1:0]     iss_src2,
    input  logic              cdb_valid,
    input  logic [TW-1:0]     cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    output logic              add_go,
    output logic [TW-1:0]     add_tag,
    output logic [1:0]        add_op,
    output logic [DATA_W-1:0] add_opa,
    output logic [DATA_W-1:0] add_opb,
    output logic              mul_go,
    output logic [TW-1:0]     mul_tag,
    output logic [1:0]        mul_op,
    output logic [DATA_W-1:0] mul_opa,
    output logic [DATA_W-1:0] mul_opb
);
    import rs_pkg::*;

    rs_op_e            op_in;
    logic              want_mul, fire;
    logic [TW-1:0]     new_tag;
    logic [NS-1:0]     slot_busy, slot_free, slot_rdy, slot_alloc, slot_gnt;
    rs_op_e            slot_op [NS];
    logic [DATA_W-1:0] slot_vj [NS];
    logic [DATA_W-1:0] slot_vk [NS];

    logic              a_pend, b_pend;
    logic [TW-1:0]     a_tag, b_tag;
    logic [DATA_W-1:0] a_val, b_val;

    logic [ADD_SLOTS-1:0] add_agnt, add_dgnt;
    logic [MUL_SLOTS-1:0] mul_agnt, mul_dgnt;
    logic [AIW-1:0]       add_aidx, add_didx;
    logic [MIW-1:0]       mul_aidx, mul_didx;
    logic                 add_aany, mul_aany, add_dany, mul_dany;

    assign op_in    = rs_op_e'(iss_op);
    assign want_mul = op_is_mul(op_in);

    // Register status table with rename on fire.
    rs_regstat #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .TW       (TW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ren_en    (fire),
        .ren_reg   (iss_dst),
        .ren_tag   (new_tag),
        .cdb_valid (cdb_valid),
        .cdb_tag   (cdb_tag),
        .cdb_value (cdb_value),
        .rd_a_reg  (iss_src1),
        .rd_b_reg  (iss_src2),
        .rd_a_pend (a_pend),
        .rd_a_tag  (a_tag),
        .rd_a_val  (a_val),
        .rd_b_pend (b_pend),
        .rd_b_tag  (b_tag),
        .rd_b_val  (b_val)
    );

    // Slot array; each slot's tag is its index.
    for (genvar s = 0; s < NS; s++) begin : g_slot
        rs_slot #(
            .DATA_W (DATA_W),
            .TW     (TW),
            .MY_TAG (s)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc     (slot_alloc[s]),
            .alloc_op  (op_in),
            .alloc_pj  (a_pend),
            .alloc_qj  (a_tag),
            .alloc_vj  (a_val),
            .alloc_pk  (b_pend),
            .alloc_qk  (b_tag),
            .alloc_vk  (b_val),
            .grant     (slot_gnt[s]),
            .cdb_valid (cdb_valid),
            .cdb_tag   (cdb_tag),
            .cdb_value (cdb_value),
            .busy_o    (slot_busy[s]),
            .free_o    (slot_free[s]),
            .ready_o   (slot_rdy[s]),
            .op_o      (slot_op[s]),
            .vj_o      (slot_vj[s]),
            .vk_o      (slot_vk[s])
        );
    end

    // Allocation pickers, one per group.
    rs_pick #(.N(ADD_SLOTS), .IW(AIW)) u_add_alloc (
        .req (slot_free[ADD_SLOTS-1:0]), .gnt (add_agnt), .idx (add_aidx), .any (add_aany));
    rs_pick #(.N(MUL_SLOTS), .IW(MIW)) u_mul_alloc (
        .req (slot_free[NS-1:ADD_SLOTS]), .gnt (mul_agnt), .idx (mul_aidx), .any (mul_aany));

    // Dispatch pickers, one per group.
    rs_pick #(.N(ADD_SLOTS), .IW(AIW)) u_add_disp (
        .req (slot_rdy[ADD_SLOTS-1:0]), .gnt (add_dgnt), .idx (add_didx), .any (add_dany));
    rs_pick #(.N(MUL_SLOTS), .IW(MIW)) u_mul_disp (
        .req (slot_rdy[NS-1:ADD_SLOTS]), .gnt (mul_dgnt), .idx (mul_didx), .any (mul_dany));

    // Issue handshake, slot allocation and new producer tag.
    always_comb begin
        iss_ready  = want_mul ? mul_aany : add_aany;
        fire       = iss_valid && iss_ready;
        slot_alloc = '0;
        if (fire) begin
            if (want_mul)
                slot_alloc[NS-1:ADD_SLOTS] = mul_agnt;
            else
                slot_alloc[ADD_SLOTS-1:0] = add_agnt;
        end
        new_tag = want_mul ? (TW'(ADD_SLOTS) + TW'(mul_aidx)) : TW'(add_aidx);
    end

    // Dispatch outputs: grant the picked slot and mux its contents.
    always_comb begin
        slot_gnt = {mul_dgnt, add_dgnt};
        add_go   = add_dany;
        add_tag  = TW'(add_didx);
        add_op   = slot_op[add_tag];
        add_opa  = slot_vj[add_tag];
        add_opb  = slot_vk[add_tag];
        mul_go   = mul_dany;
        mul_tag  = TW'(ADD_SLOTS) + TW'(mul_didx);
        mul_op   = slot_op[mul_tag];
        mul_opa  = slot_vj[mul_tag];
        mul_opb  = slot_vk[mul_tag];
    end
endmodule

// File: rtl/rs_rename_core_chk.sv
// Property checker for rs_rename_core, attached by bind below.
// Assumes the units return results only for slots already dispatched.
module rs_rename_core_chk #(
    parameter int ADD_SLOTS = 2,
    parameter int NS        = 4,
    parameter int TW        = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          iss_valid,
    input logic          iss_ready,
    input logic [1:0]    iss_op,
    input logic          add_go,
    input logic [TW-1:0] add_tag,
    input logic [1:0]    add_op,
    input logic          mul_go,
    input logic [TW-1:0] mul_tag,
    input logic [1:0]    mul_op,
    input logic [NS-1:0] slot_busy
);
    // R9: add offers carry an add-group tag
    a_r9_add_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
        add_go |-> (int'(add_tag) < ADD_SLOTS));

    // R9: multiply offers carry a multiply-group tag
    a_r9_mul_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
        mul_go |-> (int'(mul_tag) >= ADD_SLOTS));

    // R11: add port only carries add or subtract
    a_r11_add_op: assert property (@(posedge clk) disable iff (!rst_n)
        add_go |-> (add_op[1] == 1'b0));

    // R11: multiply port only carries multiply or divide
    a_r11_mul_op: assert property (@(posedge clk) disable iff (!rst_n)
        mul_go |-> (mul_op[1] == 1'b1));

    // R8: an add-type stall only happens with every add slot occupied
    a_r8_stall_full: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready && !iss_op[1]) |-> (&slot_busy[ADD_SLOTS-1:0]));

    // R9: a slot is not offered twice in back-to-back cycles
    a_r9_single_offer: assert property (@(posedge clk) disable iff (!rst_n)
        add_go |=> !(add_go && (add_tag == $past(add_tag))));
endmodule

bind rs_rename_core rs_rename_core_chk #(
    .ADD_SLOTS (ADD_SLOTS),
    .NS        (NS),
    .TW        (TW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .iss_op    (iss_op),
    .add_go    (add_go),
    .add_tag   (add_tag),
    .add_op    (add_op),
    .mul_go    (mul_go),
    .mul_tag   (mul_tag),
    .mul_op    (mul_op),
    .slot_busy (slot_busy)
);

// File: tb/tb_rs_rename_core.sv
`timescale 1ns/1ps
// Directed bench: the bench plays the functional units and drives the bus.
module tb_rs_rename_core;
    localparam logic [1:0] OPADD = 2'b00;
    localparam logic [1:0] OPSUB = 2'b01;
    localparam logic [1:0] OPMUL = 2'b10;
    localparam logic [1:0] OPDIV = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic        iss_ready;
    logic [1:0]  iss_op = '0;
    logic [2:0]  iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic        cdb_valid = 1'b0;
    logic [1:0]  cdb_tag = '0;
    logic [31:0] cdb_value = '0;
    logic        add_go, mul_go;
    logic [1:0]  add_tag, mul_tag, add_op, mul_op;
    logic [31:0] add_opa, add_opb, mul_opa, mul_opb;

    int vectors = 0;
    int fails   = 0;

    always #2.5 clk = ~clk;

    rs_rename_core dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
        .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .add_go(add_go), .add_tag(add_tag), .add_op(add_op),
        .add_opa(add_opa), .add_opb(add_opb),
        .mul_go(mul_go), .mul_tag(mul_tag), .mul_op(mul_op),
        .mul_opa(mul_opa), .mul_opb(mul_opb)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive_iss(input logic [1:0] op, input int d, input int a, input int b);
        iss_valid = 1'b1;
        iss_op    = op;
        iss_dst   = 3'(d);
        iss_src1  = 3'(a);
        iss_src2  = 3'(b);
    endtask

    task automatic issue(input logic [1:0] op, input int d, input int a, input int b);
        drive_iss(op, d, a, b);
        #1;
        check("R8 ready with a free slot", {31'd0, iss_ready}, 32'd1);
        tick;
        iss_valid = 1'b0;
    endtask

    task automatic bcast(input int t, input logic [31:0] v);
        cdb_valid = 1'b1;
        cdb_tag   = 2'(t);
        cdb_value = v;
        tick;
        cdb_valid = 1'b0;
    endtask

    // Put a value into a register: issue r0+r0, then return the result.
    task automatic set_reg(input int d, input logic [31:0] v);
        logic [1:0] t;
        issue(OPADD, d, 0, 0);
        check("R2 loader offered", {31'd0, add_go}, 32'd1);
        t = add_tag;
        bcast(int'(t), v);
    endtask

    task automatic t_reset;
        check("R1 ready after reset", {31'd0, iss_ready}, 32'd1);
        check("R1 add port idle", {31'd0, add_go}, 32'd0);
        check("R1 mul port idle", {31'd0, mul_go}, 32'd0);
        issue(OPADD, 7, 3, 4);
        check("R1 registers read zero a", add_opa, 32'd0);
        check("R1 registers read zero b", add_opb, 32'd0);
        bcast(0, 32'd0);
    endtask

    task automatic t_ready_operands;
        set_reg(1, 32'd5);
        set_reg(2, 32'd7);
        issue(OPADD, 3, 1, 2);
        check("R2 offered next cycle", {31'd0, add_go}, 32'd1);
        check("R2 operand a", add_opa, 32'd5);
        check("R2 operand b", add_opb, 32'd7);
        check("R9 lowest free tag", {30'd0, add_tag}, 32'd0);
        check("R11 add opcode", {30'd0, add_op}, 32'(OPADD));
        bcast(0, 32'd12);
    endtask

    task automatic t_raw_wait;
        issue(OPMUL, 4, 1, 2);
        check("R11 mul routed", {31'd0, mul_go}, 32'd1);
        check("R9 first mul tag", {30'd0, mul_tag}, 32'd2);
        check("R11 mul opcode", {30'd0, mul_op}, 32'(OPMUL));
        issue(OPADD, 5, 4, 1);
        check("R3 waits on tag", {31'd0, add_go}, 32'd0);
        tick;
        check("R3 still waiting", {31'd0, add_go}, 32'd0);
        cdb_valid = 1'b1; cdb_tag = 2'd2; cdb_value = 32'd35;
        #1;
        check("R3 not offered in capture cycle", {31'd0, add_go}, 32'd0);
        tick;
        cdb_valid = 1'b0;
        check("R3 offered after capture", {31'd0, add_go}, 32'd1);
        check("R3 captured value", add_opa, 32'd35);
        check("R3 other operand", add_opb, 32'd5);
        bcast(0, 32'd40);
    endtask

    task automatic t_waw;
        issue(OPMUL, 6, 1, 1);
        issue(OPSUB, 6, 2, 1);
        check("R11 sub opcode", {30'd0, add_op}, 32'(OPSUB));
        bcast(0, 32'd2);
        bcast(2, 32'd25);
        issue(OPADD, 7, 6, 0);
        check("R5 register not pending", {31'd0, add_go}, 32'd1);
        check("R4 newest producer wins", add_opa, 32'd2);
        bcast(0, 32'd9);
    endtask

    task automatic t_war;
        issue(OPMUL, 4, 1, 1);
        issue(OPDIV, 7, 2, 4);
        issue(OPADD, 2, 1, 1);
        bcast(0, 32'd99);
        check("R6 divide waits", {31'd0, mul_go}, 32'd0);
        bcast(2, 32'd25);
        check("R6 divide offered", {31'd0, mul_go}, 32'd1);
        check("R6 old value kept", mul_opa, 32'd7);
        check("R6 captured operand", mul_opb, 32'd25);
        check("R11 div opcode", {30'd0, mul_op}, 32'(OPDIV));
        check("R9 second mul tag", {30'd0, mul_tag}, 32'd3);
        bcast(3, 32'd3);
    endtask

    task automatic t_bypass;
        issue(OPMUL, 3, 1, 1);
        drive_iss(OPADD, 4, 3, 1);
        cdb_valid = 1'b1; cdb_tag = 2'd2; cdb_value = 32'd77;
        tick;
        iss_valid = 1'b0;
        cdb_valid = 1'b0;
        check("R7 offered next cycle", {31'd0, add_go}, 32'd1);
        check("R7 forwarded value", add_opa, 32'd77);
        bcast(0, 32'd1);
    endtask

    task automatic t_full;
        issue(OPADD, 5, 0, 0);
        issue(OPADD, 6, 0, 0);
        drive_iss(OPADD, 7, 1, 1);
        #1;
        check("R8 stall when group full", {31'd0, iss_ready}, 32'd0);
        tick;
        check("R8 stalled op not offered", {31'd0, add_go}, 32'd0);
        cdb_valid = 1'b1; cdb_tag = 2'd0; cdb_value = 32'd3;
        #1;
        check("R8 ready in free cycle", {31'd0, iss_ready}, 32'd1);
        tick;
        iss_valid = 1'b0;
        cdb_valid = 1'b0;
        check("R8 freed slot reused", {31'd0, add_go}, 32'd1);
        check("R8 reused tag", {30'd0, add_tag}, 32'd0);
        check("R8 reused operand", add_opa, 32'd5);
        bcast(1, 32'd4);
        bcast(0, 32'd10);
    endtask

    task automatic t_priority;
        issue(OPMUL, 3, 1, 1);
        issue(OPADD, 5, 3, 0);
        issue(OPADD, 6, 3, 1);
        bcast(2, 32'd4);
        check("R9 lowest ready first", {30'd0, add_tag}, 32'd0);
        check("R9 first operand", add_opa, 32'd4);
        tick;
        check("R9 second offered", {31'd0, add_go}, 32'd1);
        check("R9 second tag", {30'd0, add_tag}, 32'd1);
        check("R9 second operand b", add_opb, 32'd5);
        tick;
        check("R9 no repeat offer", {31'd0, add_go}, 32'd0);
        bcast(0, 32'd8);
        bcast(1, 32'd9);
    endtask

    task automatic t_stray;
        bcast(3, 32'd1234);
        check("R10 no offer after stray", {31'd0, add_go | mul_go}, 32'd0);
        issue(OPADD, 7, 1, 2);
        check("R10 slot tag unchanged", {30'd0, add_tag}, 32'd0);
        check("R10 register a unchanged", add_opa, 32'd5);
        check("R10 register b unchanged", add_opb, 32'd99);
        bcast(0, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_ready_operands;
        t_raw_wait;
        t_waw;
        t_war;
        t_bypass;
        t_full;
        t_priority;
        t_stray;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        vectors++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 5000, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule